// File: doc/BRIEF.md
# Two-Wire Serial Interface Register Block

This block is the processor-facing register logic that sits beside a two-wire serial engine. Software reaches it through a small synchronous register bus. Through that bus it arms or disarms the interface, enables the interrupt, clears the engine's event flag, requests a bus stop and picks a prescaler. Software also writes the byte to transmit. The engine reports four things back: each state change, the completion of a stop, whether it is acting as master, and a 5-bit state code.

From these inputs the block produces four results. The first is the interrupt request. The second is the prescaler divide value for the bit-rate generator. The third is a held stop command for the engine. The fourth is a one-cycle recovery pulse that returns a slave engine to an idle, unaddressed state and releases both lines.

The block also guards the transmit byte. A byte written while the event flag is low is dropped, and a collision is recorded.

Top module: `twoline_csr`

## Requirements
- R1: After reset, the control word reads 0x00, the status word reads 0xF8 when the engine reports state 5'b11111, the data word reads 0x00, `presc_div` is 1 and `irq` is 0.
- R2: The bus address selects a word: 0 is control, 1 is status, 2 is data, and 3 reads 0x00. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high.
- R3: The status word is {state code[4:0], 1'b0, prescaler select[1:0]}. Writes to status change only bits 1..0, and bit 2 always reads 0.
- R4: Prescaler select 0, 1, 2 and 3 drive `presc_div` to 1, 4, 16 and 64.
- R5: Control bit 7 is the event flag. It is set by `eng_flag_set` and cleared by writing 1 to control bit 7. Writing 0 to bit 7 leaves it unchanged, and a set in the same cycle as a clear wins.
- R6: `irq` is 1 exactly when the event flag, the interrupt-enable bit (control bit 0) and `glob_ie` are all 1.
- R7: A data-word write while the event flag is 0 sets the collision flag (control bit 3, read-only) and leaves the data word unchanged.
- R8: A data-word write while the event flag is 1 clears the collision flag and stores the byte in the data word, which drives `tx_data`.
- R9: Writing 1 to control bit 4 while enabled and `eng_master` is 1 sets the stop bit and `stop_req`. Both clear in the cycle after `eng_stop_done`, and a write of 0 to bit 4 does not clear them.
- R10: Writing 1 to control bit 4 while enabled and `eng_master` is 0 leaves `stop_req` at 0 and raises `slave_recover` for exactly one cycle.
- R11: Control bit 2 is the enable and drives `if_enable`. Writing it to 0 clears a pending stop at once and suppresses any stop request or recovery pulse in the same write. Control bits 6, 5 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| glob_ie | input | 1 | Global interrupt enable |
| eng_flag_set | input | 1 | Engine state-change pulse |
| eng_stop_done | input | 1 | Engine reports stop sent |
| eng_master | input | 1 | Engine is in master mode |
| eng_state | input | 5 | Engine state code |
| tx_data | output | 8 | Data word toward the engine |
| irq | output | 1 | Interrupt request |
| presc_div | output | 7 | Bit-rate prescaler divide value |
| stop_req | output | 1 | Held stop command |
| slave_recover | output | 1 | One-cycle slave recovery pulse |
| if_enable | output | 1 | Interface owns the pins |

## Verification
Wrong internal state shows up at the ports quickly. A flag or interrupt-enable bit stuck at the wrong value is visible on `irq` in the same cycle. A wrong collision or stop bit appears in the next control-word read, one cycle after the read strobe.

A stop bit that fails to clear keeps `stop_req` high in the cycle after `eng_stop_done`. A data byte taken during a collision changes `tx_data` in the very next cycle. Prescaler mistakes appear on `presc_div` in the cycle after the status write.

// File: rtl/twoline_csr_pkg.sv
package twoline_csr_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int STATE_W = 5;
  localparam int PSEL_W  = 2;
  localparam int DIV_W   = 2 * ((1 << PSEL_W) - 1) + 1;

  localparam logic [ADDR_W-1:0] A_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  localparam int B_FLAG = 7;
  localparam int B_STOP = 4;
  localparam int B_COL  = 3;
  localparam int B_EN   = 2;
  localparam int B_IE   = 0;

  localparam logic [STATE_W-1:0] STATE_IDLE = '1;

  // divide value selected by the prescaler field: 4 ** sel
  function automatic logic [DIV_W-1:0] presc_divide(input logic [PSEL_W-1:0] sel);
    logic [DIV_W-1:0] one;
    one = {{(DIV_W-1){1'b0}}, 1'b1};
    return one << (2 * sel);
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic [STATE_W-1:0] st,
                                                    input logic [PSEL_W-1:0] sel);
    return {st, 1'b0, sel};
  endfunction

  function automatic logic [DATA_W-1:0] control_word(input logic flag, input logic stop,
                                                     input logic col, input logic en,
                                                     input logic ie);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_FLAG] = flag;
    w[B_STOP] = stop;
    w[B_COL]  = col;
    w[B_EN]   = en;
    w[B_IE]   = ie;
    return w;
  endfunction
endpackage

// File: rtl/twoline_ctl_reg.sv
module twoline_ctl_reg
  import twoline_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_flag_set,
  input  logic              eng_stop_done,
  input  logic              eng_master,
  output logic              flag_q,
  output logic              stop_q,
  output logic              col_q,
  output logic              en_q,
  output logic              ie_q,
  output logic              recover_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] ctl_word
);
  logic en_next, wr_stop, wr_flag_clr;

  assign en_next     = ctl_wr ? wdata[B_EN] : en_q;
  assign wr_stop     = ctl_wr & wdata[B_STOP];
  assign wr_flag_clr = ctl_wr & wdata[B_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q <= wdata[B_EN];
      ie_q <= wdata[B_IE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (eng_flag_set) flag_q <= 1'b1;
    else if (wr_flag_clr)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      stop_q <= 1'b0;
    else if (!en_next)               stop_q <= 1'b0;
    else if (wr_stop && eng_master)  stop_q <= 1'b1;
    else if (eng_stop_done)          stop_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) recover_q <= 1'b0;
    else        recover_q <= en_next & wr_stop & ~eng_master;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= 1'b0;
      data_q <= '0;
    end else if (data_wr) begin
      col_q <= ~flag_q;
      if (flag_q) data_q <= wdata;
    end
  end

  assign ctl_word = control_word(flag_q, stop_q, col_q, en_q, ie_q);
endmodule

// File: rtl/twoline_stat_reg.sv
module twoline_stat_reg
  import twoline_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_wr,
  input  logic [PSEL_W-1:0]  wsel,
  input  logic [STATE_W-1:0] eng_state,
  output logic [PSEL_W-1:0]  psel_q,
  output logic [DIV_W-1:0]   div_o,
  output logic [DATA_W-1:0]  stat_word
);
  always_ff @(posedge clk) begin
    if (!rst_n)       psel_q <= '0;
    else if (stat_wr) psel_q <= wsel;
  end

  assign div_o     = presc_divide(psel_q);
  assign stat_word = status_word(eng_state, psel_q);
endmodule

// File: rtl/twoline_irq.sv
module twoline_irq (
  input  logic flag,
  input  logic ie,
  input  logic glob_ie,
  output logic irq
);
  assign irq = flag & ie & glob_ie;
endmodule

// File: rtl/twoline_csr.sv
module twoline_csr
  import twoline_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               glob_ie,
  input  logic               eng_flag_set,
  input  logic               eng_stop_done,
  input  logic               eng_master,
  input  logic [STATE_W-1:0] eng_state,
  output logic [DATA_W-1:0]  tx_data,
  output logic               irq,
  output logic [DIV_W-1:0]   presc_div,
  output logic               stop_req,
  output logic               slave_recover,
  output logic               if_enable
);
  logic ctl_wr, stat_wr, data_wr;
  logic flag_q, stop_q, col_q, en_q, ie_q, recover_q;
  logic [DATA_W-1:0] data_q, ctl_word, stat_word, rd_mux;
  logic [PSEL_W-1:0] psel_q;

  assign ctl_wr  = bus_wr && (bus_addr == A_CTL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign data_wr = bus_wr && (bus_addr == A_DATA);

  twoline_ctl_reg ctl_u (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_wr(data_wr), .wdata(bus_wdata),
    .eng_flag_set(eng_flag_set), .eng_stop_done(eng_stop_done), .eng_master(eng_master),
    .flag_q(flag_q), .stop_q(stop_q), .col_q(col_q), .en_q(en_q), .ie_q(ie_q),
    .recover_q(recover_q), .data_q(data_q), .ctl_word(ctl_word)
  );

  twoline_stat_reg stat_u (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wsel(bus_wdata[PSEL_W-1:0]),
    .eng_state(eng_state), .psel_q(psel_q), .div_o(presc_div), .stat_word(stat_word)
  );

  twoline_irq irq_u (.flag(flag_q), .ie(ie_q), .glob_ie(glob_ie), .irq(irq));

  always_comb begin
    unique case (bus_addr)
      A_CTL:   rd_mux = ctl_word;
      A_STAT:  rd_mux = stat_word;
      A_DATA:  rd_mux = data_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign tx_data       = data_q;
  assign stop_req      = stop_q;
  assign slave_recover = recover_q;
  assign if_enable     = en_q;
endmodule

// File: rtl/twoline_csr_chk.sv
module twoline_csr_chk
  import twoline_csr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               data_wr,
  input logic               ctl_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               flag_q,
  input logic               col_q,
  input logic               glob_ie,
  input logic               irq,
  input logic               eng_master,
  input logic               eng_stop_done,
  input logic               stop_req,
  input logic               slave_recover,
  input logic               if_enable,
  input logic [DIV_W-1:0]   presc_div,
  input logic [DATA_W-1:0]  tx_data
);
  AST_IRQ_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n) !glob_ie |-> !irq); // R6
  AST_COL_ON_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) data_wr && !flag_q |=> col_q && $stable(tx_data)); // R7
  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) data_wr && flag_q |=> !col_q); // R8
  AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) eng_stop_done && !ctl_wr |=> !stop_req); // R9
  AST_STOP_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n) $rose(stop_req) |-> $past(eng_master)); // R10
  AST_RECOVER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) slave_recover && !ctl_wr |=> !slave_recover); // R10
  AST_OFF_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n) !if_enable |-> !stop_req && !slave_recover); // R11
  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) $countones(presc_div) == 1 && presc_div[1] == 1'b0 && presc_div[3] == 1'b0 && presc_div[5] == 1'b0); // R4
  AST_FLAG_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr && !bus_wdata[B_FLAG] && flag_q |=> flag_q); // R5
endmodule

bind twoline_csr twoline_csr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctl_wr(ctl_wr), .bus_wdata(bus_wdata),
  .flag_q(flag_q), .col_q(col_q), .glob_ie(glob_ie), .irq(irq), .eng_master(eng_master),
  .eng_stop_done(eng_stop_done), .stop_req(stop_req), .slave_recover(slave_recover),
  .if_enable(if_enable), .presc_div(presc_div), .tx_data(tx_data)
);

// File: tb/twoline_csr_tb.sv
module twoline_csr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, tx_data;
  logic glob_ie = 1'b0, eng_flag_set = 1'b0, eng_stop_done = 1'b0, eng_master = 1'b0;
  logic [4:0] eng_state = 5'h1F;
  logic irq, stop_req, slave_recover, if_enable;
  logic [6:0] presc_div;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  twoline_csr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_ie(glob_ie),
    .eng_flag_set(eng_flag_set), .eng_stop_done(eng_stop_done), .eng_master(eng_master),
    .eng_state(eng_state), .tx_data(tx_data), .irq(irq), .presc_div(presc_div),
    .stop_req(stop_req), .slave_recover(slave_recover), .if_enable(if_enable)
  );

  // {psel, state, expected status word, expected divide}
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 5'h1F, 8'hF8, 7'd1},
    {2'd1, 5'h1F, 8'hF9, 7'd4},
    {2'd2, 5'h00, 8'h02, 7'd16},
    {2'd3, 5'h0A, 8'h53, 7'd64},
    {2'd1, 5'h15, 8'hA9, 7'd4},
    {2'd2, 5'h08, 8'h42, 7'd16}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic flag_pulse();
    @(negedge clk); eng_flag_set = 1'b1;
    @(negedge clk); eng_flag_set = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 address map
    rd(2'd0, r); chk("R1 ctl reset", r, 8'h00);
    rd(2'd1, r); chk("R1 status reset", r, 8'hF8);
    rd(2'd2, r); chk("R1 data reset", r, 8'h00);
    chk("R1 div reset", {1'b0, presc_div}, 8'd1);
    chk("R1 irq reset", {7'd0, irq}, 8'd0);
    rd(2'd3, r); chk("R2 unused address", r, 8'h00);

    // R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      eng_state = VEC[i][19:15];
      wr(2'd1, 8'hFC | {6'd0, VEC[i][21:20]});
      rd(2'd1, r); chk("R3 status word", r, VEC[i][14:7]);
      chk("R4 divide", {1'b0, presc_div}, {1'b0, VEC[i][6:0]});
    end
    eng_state = 5'h1F;

    // R2 latency: rdata holds old value before the edge that samples bus_rd
    wr(2'd1, 8'h00);
    @(negedge clk); bus_addr = 2'd1; bus_rd = 1'b1;
    chk("R2 no early data", bus_rdata, 8'h42);
    @(negedge clk); bus_rd = 1'b0;
    chk("R2 one-cycle read", bus_rdata, 8'hF8);

    // R11 reserved control bits, enable
    wr(2'd0, 8'h66);
    rd(2'd0, r); chk("R11 reserved bits read 0", r, 8'h04);
    chk("R11 if_enable", {7'd0, if_enable}, 8'd1);

    // R7 collision on early write
    wr(2'd2, 8'h3C);
    rd(2'd0, r); chk("R7 collision set", r & 8'h08, 8'h08);
    chk("R7 data kept", tx_data, 8'h00);

    // R5 flag set, zero write no effect, R6 irq gating
    flag_pulse();
    rd(2'd0, r); chk("R5 flag set", r & 8'h80, 8'h80);
    chk("R6 irq ie=0", {7'd0, irq}, 8'd0);
    wr(2'd0, 8'h05);
    chk("R6 irq gie=0", {7'd0, irq}, 8'd0);
    glob_ie = 1'b1; #1;
    chk("R6 irq all set", {7'd0, irq}, 8'd1);
    rd(2'd0, r); chk("R5 zero write keeps flag", r & 8'h80, 8'h80);

    // R8 write with flag high
    wr(2'd2, 8'h5A);
    chk("R8 data stored", tx_data, 8'h5A);
    rd(2'd0, r); chk("R8 collision cleared", r & 8'h08, 8'h00);

    // R5 write-one clear
    wr(2'd0, 8'h85);
    chk("R6 irq drops with flag", {7'd0, irq}, 8'd0);
    rd(2'd0, r); chk("R5 flag cleared", r & 8'h80, 8'h00);
    // R5 set wins over clear
    @(negedge clk); eng_flag_set = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h85; bus_wr = 1'b1;
    @(negedge clk); eng_flag_set = 1'b0; bus_wr = 1'b0;
    rd(2'd0, r); chk("R5 set beats clear", r & 8'h80, 8'h80);

    // R9 master stop
    eng_master = 1'b1;
    wr(2'd0, 8'h14);
    chk("R9 stop_req set", {7'd0, stop_req}, 8'd1);
    wr(2'd0, 8'h04);
    chk("R9 zero write keeps stop", {7'd0, stop_req}, 8'd1);
    @(negedge clk); eng_stop_done = 1'b1;
    @(negedge clk); eng_stop_done = 1'b0;
    chk("R9 stop self-clear", {7'd0, stop_req}, 8'd0);
    rd(2'd0, r); chk("R9 stop bit reads 0", r & 8'h10, 8'h00);

    // R10 slave recovery
    eng_master = 1'b0;
    wr(2'd0, 8'h14);
    chk("R10 recover pulse", {7'd0, slave_recover}, 8'd1);
    chk("R10 no stop in slave", {7'd0, stop_req}, 8'd0);
    @(negedge clk);
    chk("R10 pulse one cycle", {7'd0, slave_recover}, 8'd0);

    // R11 disable ends pending stop, suppresses stop write
    eng_master = 1'b1;
    wr(2'd0, 8'h14);
    wr(2'd0, 8'h00);
    chk("R11 disable clears stop", {7'd0, stop_req}, 8'd0);
    chk("R11 if_enable low", {7'd0, if_enable}, 8'd0);
    wr(2'd0, 8'h10);
    chk("R11 stop ignored while off", {7'd0, stop_req}, 8'd0);
    eng_master = 1'b0;
    wr(2'd0, 8'h10);
    chk("R11 no recover while off", {7'd0, slave_recover}, 8'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule